// File: doc/BRIEF.md
# String Compare Step Engine

This block carries out a single iteration of a memory-to-memory string compare. A `start` pulse hands it a source pointer, a destination pointer, an element count, a direction bit, an element width, an address width, a repeat kind and the current status-flag word. It then fetches the source element and the destination element, in that order, through a simple request/acknowledge read port. It subtracts the source element from the destination element at the selected width. Only the resulting status flags are kept, and the difference itself is dropped.

When the step ends, the block returns the advanced pointers, the count (decremented by one when a repeat kind is active), the merged flag word, and an `again_o` bit that tells the sequencer whether another iteration is due. A `fault_o` bit reports a malformed pointer or a failed read. In either of those cases the architectural outputs equal the inputs. Instruction decode and segment translation happen elsewhere. The sequencer that issues `start` re-launches the block for as long as `again_o` is returned high.

Top module: `scmp_step`

## Requirements
- R1: Flags are those of destination minus source at the width chosen by `op_size_i` (0 = 8, 1 = 16, 2 = 32, 3 = 64 bits), placed at these bit positions of the flag word:
  - bit 0: borrow out of the top bit.
  - bit 2: set when the low byte of the difference has an even number of ones.
  - bit 4: borrow out of bit 3.
  - bit 6: difference is zero.
  - bit 7: top bit of the difference.
  - bit 11: signed overflow.
- R2: Bits of either fetched element above the selected width have no effect on any output.
- R3: Every flag-word bit other than bits 0, 2, 4, 6, 7 and 11 is returned unchanged from `flags_i`.
- R4: After a completed compare, both pointers advance by 1 << `op_size_i` bytes. They move upward when `dir_i` is 0 and downward when it is 1.
- R5: Pointer and count updates depend on `addr_size_i`:
  - 0: arithmetic wraps in the low 16 bits and bits 63:16 are kept.
  - 1: arithmetic wraps in the low 32 bits and bits 63:32 are cleared.
  - 2 or 3: full 64-bit arithmetic.
- R6: Each compare issues exactly two reads, source first and destination second. Each read address is the pointer zero-extended from the address width, and each read carries `mem_size_o` = `op_size_i`. A request stays high until it is acknowledged or errored.
- R7: `rep_kind_i` encodes 1 = repeat while equal and 2 = repeat while not equal; 0 and 3 mean no repeat. With a repeat kind the count drops by one, wrapping per R5. Without a repeat kind the count is returned unchanged.
- R8: With a repeat kind and a count that is zero within the address width, the block issues no read and finishes with every output equal to its input, `again_o` = 0 and `fault_o` = 0.
- R9: `again_o` is 1 exactly when all of the following hold:
  - a repeat kind is active;
  - the new count is nonzero within the address width;
  - the new zero flag is 1 for the while-equal kind or 0 for the while-not-equal kind.
- R10: With a 64-bit address width, a source or destination pointer whose bits 63:47 are not all equal raises `fault_o`. No read is issued, and pointers, count and flags are returned unchanged.
- R11: An error response on either read raises `fault_o`, with `again_o` = 0 and pointers, count and flags returned unchanged.
- R12: `done_o` is a single-cycle pulse that marks valid outputs. `start` is ignored while a step is in progress. After reset, `done_o` and `mem_req_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one step (sampled when idle) |
| src_ptr_i | input | 64 | Source pointer |
| dst_ptr_i | input | 64 | Destination pointer |
| count_i | input | 64 | Element count |
| dir_i | input | 1 | 0 = ascending, 1 = descending |
| op_size_i | input | 2 | Element width code |
| addr_size_i | input | 2 | Address width code |
| rep_kind_i | input | 2 | Repeat kind code |
| flags_i | input | 32 | Incoming flag word |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 64 | Read address |
| mem_size_o | output | 2 | Read width code |
| mem_rdata_i | input | 64 | Read data |
| mem_ack_i | input | 1 | Read completed |
| mem_err_i | input | 1 | Read failed |
| done_o | output | 1 | Step finished, outputs valid |
| src_ptr_o | output | 64 | Updated source pointer |
| dst_ptr_o | output | 64 | Updated destination pointer |
| count_o | output | 64 | Updated count |
| flags_o | output | 32 | Updated flag word |
| again_o | output | 1 | Another iteration is due |
| fault_o | output | 1 | Step aborted |

## Verification
The embedded assertions check several properties on every cycle:
- the single-cycle `done_o` pulse;
- pass-through of the non-status flag bits;
- canonical form of every 64-bit read address;
- an unchanged state on every fault;
- that a zero flag never coexists with a borrow or an overflow after a real compare;
- that `again_o` only appears under a repeat kind.

The exact flag values at each width, the pointer wrap at 16 and 32 bits, the stop conditions of both repeat kinds, the read ordering, and the refusal of a second `start` can only be shown by the bench's sweeps. These sweeps cover every width, direction, address width and repeat kind against four data patterns and varied read latency.

// File: rtl/scmp_pkg.sv
package scmp_pkg;
  localparam int FLB_CF = 0;
  localparam int FLB_PF = 2;
  localparam int FLB_AF = 4;
  localparam int FLB_ZF = 6;
  localparam int FLB_SF = 7;
  localparam int FLB_OF = 11;

  localparam logic [1:0] ASZ_16 = 2'd0;
  localparam logic [1:0] ASZ_32 = 2'd1;

  localparam logic [1:0] RK_EQ = 2'd1;
  localparam logic [1:0] RK_NE = 2'd2;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } sflags_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_EVAL,
    S_RD_SRC,
    S_RD_DST,
    S_DONE
  } step_st_t;
endpackage

// File: rtl/scmp_sub_flags.sv
module scmp_sub_flags
  import scmp_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] minuend,
  input  logic [DATA_W-1:0] subtrahend,
  input  logic [1:0]        width_sel,
  output sflags_t           flags
);
  localparam int N_LANES = $clog2(DATA_W / 8) + 1;

  sflags_t [N_LANES-1:0] lane;

  // One subtractor per element width; the width code picks a lane.
  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    localparam int W = 8 << k;
    logic [W:0] dif;
    logic       l_cf, l_zf, l_sf, l_of, l_pf, l_af;

    assign dif  = {1'b0, minuend[W-1:0]} - {1'b0, subtrahend[W-1:0]};
    assign l_cf = dif[W];
    assign l_zf = (dif[W-1:0] == '0);
    assign l_sf = dif[W-1];
    assign l_of = (minuend[W-1] ^ subtrahend[W-1]) & (minuend[W-1] ^ dif[W-1]);
    assign l_pf = ~^dif[7:0];
    assign l_af = minuend[4] ^ subtrahend[4] ^ dif[4];
    assign lane[k] = {l_of, l_sf, l_zf, l_af, l_pf, l_cf};
  end

  assign flags = lane[width_sel];
endmodule

// File: rtl/scmp_addr_step.sv
module scmp_addr_step
  import scmp_pkg::*;
#(
  parameter int PTR_W = 64
) (
  input  logic [PTR_W-1:0] val,
  input  logic [PTR_W-1:0] delta,
  input  logic [1:0]       asz,
  output logic [PTR_W-1:0] stepped,
  output logic [PTR_W-1:0] eff
);
  localparam int LO16 = 16;
  localparam int LO32 = 32;

  logic [PTR_W-1:0] sum;
  assign sum = val + delta;

  always_comb begin
    unique case (asz)
      ASZ_16: begin
        stepped = {val[PTR_W-1:LO16], sum[LO16-1:0]};
        eff     = {{(PTR_W-LO16){1'b0}}, val[LO16-1:0]};
      end
      ASZ_32: begin
        stepped = {{(PTR_W-LO32){1'b0}}, sum[LO32-1:0]};
        eff     = {{(PTR_W-LO32){1'b0}}, val[LO32-1:0]};
      end
      default: begin
        stepped = sum;
        eff     = val;
      end
    endcase
  end
endmodule

// File: rtl/scmp_step.sv
module scmp_step
  import scmp_pkg::*;
#(
  parameter int PTR_W   = 64,
  parameter int DATA_W  = 64,
  parameter int FLAG_W  = 32,
  parameter int VA_BITS = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PTR_W-1:0]  src_ptr_i,
  input  logic [PTR_W-1:0]  dst_ptr_i,
  input  logic [PTR_W-1:0]  count_i,
  input  logic              dir_i,
  input  logic [1:0]        op_size_i,
  input  logic [1:0]        addr_size_i,
  input  logic [1:0]        rep_kind_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              mem_req_o,
  output logic [PTR_W-1:0]  mem_addr_o,
  output logic [1:0]        mem_size_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  output logic              done_o,
  output logic [PTR_W-1:0]  src_ptr_o,
  output logic [PTR_W-1:0]  dst_ptr_o,
  output logic [PTR_W-1:0]  count_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              again_o,
  output logic              fault_o
);
  localparam int N_CH  = 3;
  localparam int CH_SRC = 0;
  localparam int CH_DST = 1;
  localparam int CH_CNT = 2;
  localparam int TOP_HI = PTR_W - 1;
  localparam int TOP_LO = VA_BITS - 1;
  localparam logic [FLAG_W-1:0] ARITH_MASK =
    (FLAG_W'(1) << FLB_CF) | (FLAG_W'(1) << FLB_PF) | (FLAG_W'(1) << FLB_AF) |
    (FLAG_W'(1) << FLB_ZF) | (FLAG_W'(1) << FLB_SF) | (FLAG_W'(1) << FLB_OF);

  function automatic logic is_canon(input logic [PTR_W-1:0] p);
    return (p[TOP_HI:TOP_LO] == '0) || (&p[TOP_HI:TOP_LO]);
  endfunction

  function automatic logic [PTR_W-1:0] width_mask(input logic [PTR_W-1:0] v,
                                                  input logic [1:0] az);
    unique case (az)
      ASZ_16:  return {{(PTR_W-16){1'b0}}, v[15:0]};
      ASZ_32:  return {{(PTR_W-32){1'b0}}, v[31:0]};
      default: return v;
    endcase
  endfunction

  // Latched step inputs
  step_st_t          st, st_n;
  logic [PTR_W-1:0]  src_q, dst_q, cnt_q;
  logic              dir_q;
  logic [1:0]        os_q, asz_q, rep_q;
  logic [FLAG_W-1:0] fl_q;
  logic [DATA_W-1:0] sdat_q;

  // Control strobes
  logic lat_en, sdat_en, out_en, out_upd, out_flt;

  // Derived values
  logic              rep_act, asz64, cont;
  logic [PTR_W-1:0]  elem_bytes, elem_delta;
  logic [PTR_W-1:0]  ch_in    [N_CH];
  logic [PTR_W-1:0]  ch_delta [N_CH];
  logic [PTR_W-1:0]  ch_step  [N_CH];
  logic [PTR_W-1:0]  ch_eff   [N_CH];
  logic [PTR_W-1:0]  cnt_new;
  sflags_t           cmp_f;
  logic [FLAG_W-1:0] merged;

  logic [PTR_W-1:0]  src_n, dst_n, cnt_n;
  logic [FLAG_W-1:0] fl_n;
  logic              again_n;

  assign rep_act    = (rep_q == RK_EQ) || (rep_q == RK_NE);
  assign asz64      = asz_q[1];
  assign elem_bytes = PTR_W'(1) << os_q;
  assign elem_delta = dir_q ? (PTR_W'(0) - elem_bytes) : elem_bytes;

  assign ch_in[CH_SRC]    = src_q;
  assign ch_in[CH_DST]    = dst_q;
  assign ch_in[CH_CNT]    = cnt_q;
  assign ch_delta[CH_SRC] = elem_delta;
  assign ch_delta[CH_DST] = elem_delta;
  assign ch_delta[CH_CNT] = '1;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    scmp_addr_step #(.PTR_W(PTR_W)) u_step (
      .val     (ch_in[c]),
      .delta   (ch_delta[c]),
      .asz     (asz_q),
      .stepped (ch_step[c]),
      .eff     (ch_eff[c])
    );
  end

  scmp_sub_flags #(.DATA_W(DATA_W)) u_flags (
    .minuend    (mem_rdata_i),
    .subtrahend (sdat_q),
    .width_sel  (os_q),
    .flags      (cmp_f)
  );

  always_comb begin
    merged         = fl_q;
    merged[FLB_CF] = cmp_f.cf;
    merged[FLB_PF] = cmp_f.pf;
    merged[FLB_AF] = cmp_f.af;
    merged[FLB_ZF] = cmp_f.zf;
    merged[FLB_SF] = cmp_f.sf;
    merged[FLB_OF] = cmp_f.of;
  end

  assign cnt_new = rep_act ? ch_step[CH_CNT] : cnt_q;
  assign cont    = rep_act && (width_mask(cnt_new, asz_q) != '0) &&
                   ((rep_q == RK_EQ) ? cmp_f.zf : !cmp_f.zf);

  // Next-state logic
  always_comb begin
    st_n    = st;
    lat_en  = 1'b0;
    sdat_en = 1'b0;
    out_en  = 1'b0;
    out_upd = 1'b0;
    out_flt = 1'b0;
    unique case (st)
      S_IDLE: if (start) begin
        lat_en = 1'b1;
        st_n   = S_EVAL;
      end
      S_EVAL: begin
        if (rep_act && (ch_eff[CH_CNT] == '0)) begin
          out_en = 1'b1;
          st_n   = S_DONE;
        end else if (asz64 && (!is_canon(src_q) || !is_canon(dst_q))) begin
          out_en  = 1'b1;
          out_flt = 1'b1;
          st_n    = S_DONE;
        end else begin
          st_n = S_RD_SRC;
        end
      end
      S_RD_SRC: begin
        if (mem_err_i) begin
          out_en  = 1'b1;
          out_flt = 1'b1;
          st_n    = S_DONE;
        end else if (mem_ack_i) begin
          sdat_en = 1'b1;
          st_n    = S_RD_DST;
        end
      end
      S_RD_DST: begin
        if (mem_err_i) begin
          out_en  = 1'b1;
          out_flt = 1'b1;
          st_n    = S_DONE;
        end else if (mem_ack_i) begin
          out_en  = 1'b1;
          out_upd = 1'b1;
          st_n    = S_DONE;
        end
      end
      S_DONE:  st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_comb begin
    src_n   = out_upd ? ch_step[CH_SRC] : src_q;
    dst_n   = out_upd ? ch_step[CH_DST] : dst_q;
    cnt_n   = out_upd ? cnt_new : cnt_q;
    fl_n    = out_upd ? merged : fl_q;
    again_n = out_upd & cont;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= st_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0; dst_q <= '0; cnt_q <= '0; dir_q <= 1'b0;
      os_q  <= '0; asz_q <= '0; rep_q <= '0; fl_q  <= '0;
    end else if (lat_en) begin
      src_q <= src_ptr_i;   dst_q <= dst_ptr_i;  cnt_q <= count_i;
      dir_q <= dir_i;       os_q  <= op_size_i;  asz_q <= addr_size_i;
      rep_q <= rep_kind_i;  fl_q  <= flags_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sdat_q <= '0;
    else if (sdat_en) sdat_q <= mem_rdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_ptr_o <= '0; dst_ptr_o <= '0; count_o <= '0;
      flags_o   <= '0; again_o   <= 1'b0; fault_o <= 1'b0;
    end else if (out_en) begin
      src_ptr_o <= src_n; dst_ptr_o <= dst_n; count_o <= cnt_n;
      flags_o   <= fl_n;  again_o   <= again_n; fault_o <= out_flt;
    end
  end

  assign done_o     = (st == S_DONE);
  assign mem_req_o  = (st == S_RD_SRC) || (st == S_RD_DST);
  assign mem_addr_o = (st == S_RD_DST) ? ch_eff[CH_DST] : ch_eff[CH_SRC];
  assign mem_size_o = os_q;

  // Assertions
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_zero_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_EVAL && rep_act && ch_eff[CH_CNT] == '0) |=>
      (done_o && !again_o && !fault_o && count_o == cnt_q && flags_o == fl_q));

  a_r10_canon_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && asz64) |-> is_canon(mem_addr_o));

  a_r3_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((flags_o & ~ARITH_MASK) == (fl_q & ~ARITH_MASK)));

  a_r11_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && fault_o) |-> (!again_o && flags_o == fl_q && src_ptr_o == src_q &&
                             dst_ptr_o == dst_q && count_o == cnt_q));

  a_r1_zf_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD_DST && mem_ack_i && !mem_err_i) |=>
      (!flags_o[FLB_ZF] || (!flags_o[FLB_CF] && !flags_o[FLB_OF])));

  a_r9_again_needs_rep: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && again_o) |-> rep_act);
endmodule

// File: tb/scmp_step_bench.sv
module scmp_step_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [63:0] src_ptr_i, dst_ptr_i, count_i;
  logic        dir_i;
  logic [1:0]  op_size_i, addr_size_i, rep_kind_i;
  logic [31:0] flags_i;
  logic        mem_req_o;
  logic [63:0] mem_addr_o;
  logic [1:0]  mem_size_o;
  logic [63:0] mem_rdata_i;
  logic        mem_ack_i, mem_err_i;
  logic        done_o;
  logic [63:0] src_ptr_o, dst_ptr_o, count_o;
  logic [31:0] flags_o;
  logic        again_o, fault_o;

  localparam logic [31:0] STAT_MASK = 32'h0000_08D5;

  int n_chk = 0;
  int n_err = 0;

  int          r_nreads;
  logic [63:0] r_addr0, r_addr1;
  bit          r_size_bad, r_found;

  always #5 clk = ~clk;

  scmp_step u_scmp_step (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_ptr_i(src_ptr_i), .dst_ptr_i(dst_ptr_i), .count_i(count_i),
    .dir_i(dir_i), .op_size_i(op_size_i), .addr_size_i(addr_size_i),
    .rep_kind_i(rep_kind_i), .flags_i(flags_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_size_o(mem_size_o),
    .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i), .mem_err_i(mem_err_i),
    .done_o(done_o), .src_ptr_o(src_ptr_o), .dst_ptr_o(dst_ptr_o),
    .count_o(count_o), .flags_o(flags_o), .again_o(again_o), .fault_o(fault_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] b_eff(input logic [63:0] p, input logic [1:0] az);
    if (az == 2'd0) return p & 64'hFFFF;
    if (az == 2'd1) return p & 64'hFFFF_FFFF;
    return p;
  endfunction

  function automatic logic [63:0] b_step(input logic [63:0] p, input logic [63:0] d,
                                         input logic [1:0] az);
    logic [63:0] s;
    s = p + d;
    if (az == 2'd0) return (p & 64'hFFFF_FFFF_FFFF_0000) | (s & 64'hFFFF);
    if (az == 2'd1) return s & 64'hFFFF_FFFF;
    return s;
  endfunction

  function automatic bit b_canon(input logic [63:0] p);
    return (p >> 47) == 64'd0 || (p >> 47) == 64'h1_FFFF;
  endfunction

  function automatic logic [31:0] b_flags(input logic [31:0] fl, input logic [63:0] d,
                                          input logic [63:0] s, input logic [1:0] os);
    int          w;
    logic [63:0] m, dm, sm, df;
    bit          cf, zf, sf, of, pf, af;
    w  = 8 << os;
    m  = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    dm = d & m;
    sm = s & m;
    df = (dm - sm) & m;
    cf = dm < sm;
    zf = (df == 64'd0);
    sf = df[w-1];
    of = (dm[w-1] != sm[w-1]) && (df[w-1] != dm[w-1]);
    pf = ~^df[7:0];
    af = dm[3:0] < sm[3:0];
    return (fl & ~STAT_MASK) | {20'd0, of, 3'd0, sf, zf, 1'b0, af, 1'b0, pf, 1'b0, cf};
  endfunction

  task automatic run_step(input logic [63:0] sp, input logic [63:0] dp, input logic [63:0] cn,
                          input logic dr, input logic [1:0] os, input logic [1:0] az,
                          input logic [1:0] rk, input logic [31:0] fl,
                          input logic [63:0] sd, input logic [63:0] dd,
                          input int lat, input int err_at, input bit inject);
    int w;
    w = 0; r_nreads = 0; r_addr0 = '0; r_addr1 = '0; r_size_bad = 0; r_found = 0;
    @(negedge clk);
    src_ptr_i = sp; dst_ptr_i = dp; count_i = cn; dir_i = dr; op_size_i = os;
    addr_size_i = az; rep_kind_i = rk; flags_i = fl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 60; c++) begin
      if (c == 0 && inject) begin
        start = 1'b1; src_ptr_i = ~sp; count_i = 64'd0; rep_kind_i = 2'd1;
      end
      if (c == 1) start = 1'b0;
      if (mem_ack_i || mem_err_i) begin
        mem_ack_i = 1'b0; mem_err_i = 1'b0;
      end else if (mem_req_o) begin
        if (w >= lat) begin
          if (r_nreads == 0) r_addr0 = mem_addr_o; else r_addr1 = mem_addr_o;
          if (mem_size_o != os) r_size_bad = 1;
          mem_rdata_i = (r_nreads == 0) ? sd : dd;
          if (r_nreads + 1 == err_at) mem_err_i = 1'b1; else mem_ack_i = 1'b1;
          r_nreads++;
          w = 0;
        end else w++;
      end
      if (done_o) begin
        r_found = 1;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic check_step(input logic [63:0] sp, input logic [63:0] dp, input logic [63:0] cn,
                            input logic dr, input logic [1:0] os, input logic [1:0] az,
                            input logic [1:0] rk, input logic [31:0] fl,
                            input logic [63:0] sd, input logic [63:0] dd,
                            input int lat, input int err_at, input bit inject, input string ftag);
    bit          rep, zexit, cflt, flt, upd, eagain;
    int          ereads;
    logic [63:0] delta, esrc, edst, ecnt;
    logic [31:0] efl;
    rep   = (rk == 2'd1) || (rk == 2'd2);
    zexit = rep && (b_eff(cn, az) == 64'd0);
    cflt  = !zexit && az[1] && (!b_canon(sp) || !b_canon(dp));
    ereads = (zexit || cflt) ? 0 : ((err_at == 1) ? 1 : 2);
    flt   = cflt || (ereads > 0 && err_at != 0);
    upd   = !zexit && !flt;
    delta = dr ? (64'd0 - (64'd1 << os)) : (64'd1 << os);
    esrc  = upd ? b_step(sp, delta, az) : sp;
    edst  = upd ? b_step(dp, delta, az) : dp;
    ecnt  = (upd && rep) ? b_step(cn, 64'hFFFF_FFFF_FFFF_FFFF, az) : cn;
    efl   = upd ? b_flags(fl, dd, sd, os) : fl;
    eagain = upd && rep && (b_eff(ecnt, az) != 64'd0) &&
             ((rk == 2'd1) ? efl[6] : !efl[6]);

    run_step(sp, dp, cn, dr, os, az, rk, fl, sd, dd, lat, err_at, inject);

    chk("R12 done seen", 64'(r_found), 64'd1);
    chk({ftag, " flags"}, 64'(flags_o), 64'(efl));
    chk("R3 other flag bits", 64'(flags_o & ~STAT_MASK), 64'(fl & ~STAT_MASK));
    chk("R4 R5 src ptr", src_ptr_o, esrc);
    chk("R4 R5 dst ptr", dst_ptr_o, edst);
    chk("R7 count", count_o, ecnt);
    chk("R9 again", 64'(again_o), 64'(eagain));
    chk("R10 R11 fault", 64'(fault_o), 64'(flt));
    chk("R6 R8 read count", 64'(r_nreads), 64'(ereads));
    if (ereads >= 1) chk("R6 src addr", r_addr0, b_eff(sp, az));
    if (ereads >= 2) chk("R6 dst addr", r_addr1, b_eff(dp, az));
    if (ereads >= 1) chk("R6 size", 64'(r_size_bad), 64'd0);
  endtask

  function automatic logic [63:0] pat_d(input int p);
    case (p)
      0: return 64'h1234_5678_9ABC_DEF0;
      1: return 64'h0;
      2: return 64'h8000_0000_8000_8080;
      default: return 64'hAAAA_AAAA_AAAA_AA5C;
    endcase
  endfunction

  function automatic logic [63:0] pat_s(input int p);
    case (p)
      0: return 64'h1234_5678_9ABC_DEF0;
      1: return 64'h1;
      2: return 64'h0000_0001_0000_0101;
      default: return 64'h5555_5555_5555_555C;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  localparam logic [63:0] SP0 = 64'hFFFF_FFFF_0000_FFFE;
  localparam logic [63:0] DP0 = 64'h0000_1234_5678_0003;

  initial begin
    rst_n = 1'b0; start = 1'b0; src_ptr_i = '0; dst_ptr_i = '0; count_i = '0;
    dir_i = 1'b0; op_size_i = '0; addr_size_i = '0; rep_kind_i = '0; flags_i = '0;
    mem_rdata_i = '0; mem_ack_i = 1'b0; mem_err_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 reset done", 64'(done_o), 64'd0);
    chk("R12 reset req", 64'(mem_req_o), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 idle req", 64'(mem_req_o), 64'd0);

    // Sweep: width x direction x address width x repeat kind x data pattern
    for (int os = 0; os < 4; os++)
      for (int dr = 0; dr < 2; dr++)
        for (int az = 0; az < 3; az++)
          for (int rk = 0; rk < 3; rk++)
            for (int p = 0; p < 4; p++)
              check_step(SP0, DP0, 64'd5, dr[0], os[1:0], az[1:0], rk[1:0],
                         (p % 2 == 0) ? 32'h0003_0FFF : 32'h0024_0200,
                         pat_s(p), pat_d(p), (os + p) % 3, 0, 0,
                         (p == 3) ? "R2" : "R1");

    // R12: done falls after one cycle
    @(negedge clk);
    chk("R12 done pulse", 64'(done_o), 64'd0);

    // R8: zero count with repeat, masked by address width
    check_step(SP0, DP0, 64'h0001_0000, 0, 2'd0, 2'd0, 2'd1, 32'h0000_0ACD,
               64'd1, 64'd2, 0, 0, 0, "R8");
    check_step(SP0, DP0, 64'h1_0000_0000, 1, 2'd2, 2'd1, 2'd2, 32'h0000_0041,
               64'd1, 64'd2, 1, 0, 0, "R8");
    check_step(SP0, DP0, 64'h0001_0000, 0, 2'd0, 2'd1, 2'd1, 32'h0000_0000,
               64'd7, 64'd7, 0, 0, 0, "R8");
    // R7: no repeat, zero count still compares and leaves the count alone
    check_step(SP0, DP0, 64'd0, 0, 2'd3, 2'd2, 2'd0, 32'h0000_0000,
               64'd3, 64'd9, 2, 0, 0, "R7");
    check_step(SP0, DP0, 64'd0, 0, 2'd1, 2'd1, 2'd3, 32'h0000_0000,
               64'd3, 64'd3, 0, 0, 0, "R7");
    // R9: last element stops both kinds
    check_step(SP0, DP0, 64'd1, 0, 2'd0, 2'd2, 2'd1, 32'h0, 64'h44, 64'h44, 0, 0, 0, "R9");
    check_step(SP0, DP0, 64'h1_0001, 1, 2'd2, 2'd0, 2'd2, 32'h0, 64'h44, 64'h45, 0, 0, 0, "R9");
    // R10: non-canonical source, destination; no fault at 32-bit width
    check_step(64'h0000_8000_0000_0000, DP0, 64'd3, 0, 2'd0, 2'd2, 2'd1, 32'h0000_0123,
               64'd1, 64'd1, 0, 0, 0, "R10");
    check_step(SP0, 64'h7FFF_0000_0000_0000, 64'd3, 0, 2'd0, 2'd3, 2'd0, 32'h0000_0123,
               64'd1, 64'd1, 0, 0, 0, "R10");
    check_step(64'h0000_8000_0000_0010, DP0, 64'd3, 0, 2'd2, 2'd1, 2'd1, 32'h0000_0123,
               64'd1, 64'd1, 0, 0, 0, "R10");
    // R11: read errors
    check_step(SP0, DP0, 64'd3, 0, 2'd1, 2'd2, 2'd1, 32'h0000_0ED5,
               64'd1, 64'd1, 1, 1, 0, "R11");
    check_step(SP0, DP0, 64'd3, 1, 2'd3, 2'd0, 2'd2, 32'h0000_0ED5,
               64'd1, 64'd2, 2, 2, 0, "R11");
    // R12: second start during a step is ignored
    check_step(SP0, DP0, 64'd9, 0, 2'd2, 2'd2, 2'd1, 32'h0000_0000,
               64'h10, 64'h10, 1, 0, 1, "R12");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule